// File: doc/BRIEF.md
# Flash Block Erase-Verify Sequencer

This block runs the erase protocol of an on-chip flash array in hardware. A request names a set of blocks as a bit mask. The sequencer takes the named blocks one at a time, in ascending index order, and runs a full erase attempt on each. An attempt drives the array's control strobes in a fixed order with a programmed settling wait after every edge, and it arms a watchdog-enable output around the erase pulse. Each attempt ends with a verify pass. The verify pass walks the block one 16-bit word at a time. For each word it issues a dummy 0xFF write, waits, and then reads the word back through a plain read port.

A block whose words all read back as 0xFFFF is complete. A block that shows a cleared bit is erased again, up to a bounded number of attempts. Once every named block has passed, or one block has used up its attempts, software-write enable is dropped and the block waits one more settling period. It then pulses `done` and reports pass or fail, together with the index of the failing block. All waits are parameters counted in clock cycles, and one down-counter times every wait.

Top module: `erase_seq`

## Requirements
- R1: During and right after a synchronous active-high reset, every strobe, `busy`, `done`, `fail` and `fail_block_index` are 0.
- R2: An accepted `start` raises `flash_swe` alone for D_SWE_ON+1 cycles before any other strobe. `flash_swe` stays high until the closing phase, and `flash_esu` is never high without it.
- R3: `flash_blk_sel` is one-hot while a block is worked on and all-zero otherwise. A request with an all-zero mask is rejected: `done` pulses for one cycle with `fail`=1 and `fail_block_index`=0, and no strobe moves.
- R4: An attempt holds select, `wdt_en` and `flash_esu` for D_ESU_ON+1 cycles. It then adds `flash_epulse` for D_EP_ON+1 cycles, drops the pulse for D_EP_OFF+1 cycles, and drops `flash_esu` for D_ESU_OFF+1 cycles. `wdt_en` falls as verify begins and is high whenever the pulse is high.
- R5: Verify raises `flash_ev` for D_EV_ON+1 cycles. Then, for each word from the block base (index × BLK_WORDS) upward, it gives one cycle of `mem_wr`, D_VWAIT+1 cycles of wait, and one cycle of `mem_rd` at the same address.
- R6: A word passes only when `mem_rdata` is 16'hFFFF. The first word that does not pass ends the verify pass of that attempt.
- R7: After each verify pass, `flash_ev` drops for D_EV_OFF+1 cycles. A failed block is re-attempted until it has had TRY_MAX attempts, and the attempt count starts again at 1 for every block.
- R8: When a block fails its last allowed attempt, no further block is started. `fail`=1 and `fail_block_index` = that block's index from the closing phase onward, held until the next accepted start.
- R9: After the last block passes, or after a failure, `flash_swe` is low for D_SWE_OFF+1 cycles and then `done` is high for one cycle. `fail`=0 when all blocks passed.
- R10: `busy` is high from the cycle after an accepted start through the `done` cycle, and a `start` that arrives while `busy` is high has no effect.
- R11: `mem_wr` is high only inside verify with `flash_ev` high, carrying `mem_wdata`=8'hFF. No other write is made, so no pre-write of the block takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, sampled while idle |
| req_blocks | input | NB | Mask of blocks to erase |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Last operation failed or was rejected |
| fail_block_index | output | $clog2(NB) | Index of the block that failed |
| flash_swe | output | 1 | Software-write enable to the array |
| flash_blk_sel | output | NB | One-hot erase block select |
| flash_esu | output | 1 | Erase setup |
| flash_epulse | output | 1 | Erase pulse |
| flash_ev | output | 1 | Erase-verify mode |
| wdt_en | output | 1 | Watchdog arm |
| mem_wr | output | 1 | Dummy write strobe |
| mem_wdata | output | 8 | Dummy write data |
| mem_rd | output | 1 | Verify read strobe |
| mem_addr | output | $clog2(NB*BLK_WORDS) | Verify word address |
| mem_rdata | input | DATA_W | Word read back, valid in the `mem_rd` cycle |

## Verification
The hardest case to reach from the ports is a multi-block request where one block passes only on its last allowed attempt and the next block needs a retry. Only this case shows whether the attempt counter restarts for each block. The bench's array model counts the erase pulses each block receives. It keeps one chosen word, with a chosen bad value, reading wrong until that block has had a set number of pulses, so the retry count of every block is set from the stimulus. A second `start` is injected in the middle of that run, and separate runs cover exhaustion of the attempt limit and an empty mask.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SWE_ON,
        ST_ESU_ON,
        ST_EP_ON,
        ST_EP_OFF,
        ST_ESU_OFF,
        ST_EV_ON,
        ST_VWR,
        ST_VWAIT,
        ST_VRD,
        ST_EV_OFF,
        ST_SWE_OFF,
        ST_FIN
    } seq_state_e;

    typedef struct packed {
        logic swe;
        logic sel;
        logic esu;
        logic pulse;
        logic wdt;
        logic ev;
        logic wr;
        logic rd;
    } strobe_t;

    localparam logic [7:0] DUMMY_BYTE = 8'hFF;

    function automatic strobe_t strobes_of(seq_state_e s);
        strobe_t o;
        o = '0;
        case (s)
            ST_SWE_ON:  o.swe = 1'b1;
            ST_ESU_ON,
            ST_EP_OFF:  begin o.swe = 1'b1; o.sel = 1'b1; o.esu = 1'b1; o.wdt = 1'b1; end
            ST_EP_ON:   begin o.swe = 1'b1; o.sel = 1'b1; o.esu = 1'b1; o.wdt = 1'b1; o.pulse = 1'b1; end
            ST_ESU_OFF: begin o.swe = 1'b1; o.sel = 1'b1; o.wdt = 1'b1; end
            ST_EV_ON,
            ST_VWAIT:   begin o.swe = 1'b1; o.sel = 1'b1; o.ev = 1'b1; end
            ST_VWR:     begin o.swe = 1'b1; o.sel = 1'b1; o.ev = 1'b1; o.wr = 1'b1; end
            ST_VRD:     begin o.swe = 1'b1; o.sel = 1'b1; o.ev = 1'b1; o.rd = 1'b1; end
            ST_EV_OFF:  begin o.swe = 1'b1; o.sel = 1'b1; end
            default:    o = '0;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/erase_wait_timer.sv
module erase_wait_timer #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    // R4
    load_take_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> cnt == $past(load_val));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && expired) |=> expired);
endmodule

// File: rtl/erase_blk_pick.sv
module erase_blk_pick #(
    parameter int NB = 4,
    parameter int IW = 2
) (
    input  logic [NB-1:0] mask,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |mask;
        idx = '0;
        for (int i = NB - 1; i >= 0; i--) begin
            if (mask[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/erase_seq.sv
module erase_seq
    import erase_seq_pkg::*;
#(
    parameter int NB        = 4,
    parameter int BLK_WORDS = 8,
    parameter int DATA_W    = 16,
    parameter int TRY_MAX   = 3,
    parameter int CNT_W     = 20,
    parameter int D_SWE_ON  = 3,
    parameter int D_ESU_ON  = 2,
    parameter int D_EP_ON   = 12,
    parameter int D_EP_OFF  = 2,
    parameter int D_ESU_OFF = 2,
    parameter int D_EV_ON   = 3,
    parameter int D_VWAIT   = 1,
    parameter int D_EV_OFF  = 2,
    parameter int D_SWE_OFF = 4
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              start,
    input  logic [NB-1:0]                     req_blocks,
    output logic                              busy,
    output logic                              done,
    output logic                              fail,
    output logic [$clog2(NB)-1:0]             fail_block_index,
    output logic                              flash_swe,
    output logic [NB-1:0]                     flash_blk_sel,
    output logic                              flash_esu,
    output logic                              flash_epulse,
    output logic                              flash_ev,
    output logic                              wdt_en,
    output logic                              mem_wr,
    output logic [7:0]                        mem_wdata,
    output logic                              mem_rd,
    output logic [$clog2(NB*BLK_WORDS)-1:0]   mem_addr,
    input  logic [DATA_W-1:0]                 mem_rdata
);
    localparam int IW = $clog2(NB);
    localparam int AW = $clog2(NB * BLK_WORDS);
    localparam int WW = $clog2(BLK_WORDS);
    localparam int TW = $clog2(TRY_MAX + 1);

    seq_state_e    state, nxt;
    logic [NB-1:0] pend, rest, pick_in;
    logic [IW-1:0] cur, pick_idx;
    logic [WW-1:0] wcnt;
    logic [TW-1:0] tries;
    logic          vpass, fail_q, pick_any, expired, word_ok, word_last;
    logic [IW-1:0] fidx_q;
    strobe_t       stb;

    function automatic logic [CNT_W-1:0] wait_of(seq_state_e s);
        case (s)
            ST_SWE_ON:  return CNT_W'(D_SWE_ON);
            ST_ESU_ON:  return CNT_W'(D_ESU_ON);
            ST_EP_ON:   return CNT_W'(D_EP_ON);
            ST_EP_OFF:  return CNT_W'(D_EP_OFF);
            ST_ESU_OFF: return CNT_W'(D_ESU_OFF);
            ST_EV_ON:   return CNT_W'(D_EV_ON);
            ST_VWAIT:   return CNT_W'(D_VWAIT);
            ST_EV_OFF:  return CNT_W'(D_EV_OFF);
            ST_SWE_OFF: return CNT_W'(D_SWE_OFF);
            default:    return '0;
        endcase
    endfunction

    assign rest      = pend & ~(NB'(1) << cur);
    assign pick_in   = (state == ST_IDLE) ? req_blocks : rest;
    assign word_ok   = (mem_rdata == {DATA_W{1'b1}});
    assign word_last = (wcnt == WW'(BLK_WORDS - 1));

    erase_blk_pick #(.NB(NB), .IW(IW)) u_pick (
        .mask (pick_in),
        .any  (pick_any),
        .idx  (pick_idx)
    );

    erase_wait_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (nxt != state),
        .load_val (wait_of(nxt)),
        .expired  (expired)
    );

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:    if (start) nxt = pick_any ? ST_SWE_ON : ST_FIN;
            ST_SWE_ON:  if (expired) nxt = ST_ESU_ON;
            ST_ESU_ON:  if (expired) nxt = ST_EP_ON;
            ST_EP_ON:   if (expired) nxt = ST_EP_OFF;
            ST_EP_OFF:  if (expired) nxt = ST_ESU_OFF;
            ST_ESU_OFF: if (expired) nxt = ST_EV_ON;
            ST_EV_ON:   if (expired) nxt = ST_VWR;
            ST_VWR:     nxt = ST_VWAIT;
            ST_VWAIT:   if (expired) nxt = ST_VRD;
            ST_VRD:     nxt = (word_ok && !word_last) ? ST_VWR : ST_EV_OFF;
            ST_EV_OFF: begin
                if (expired) begin
                    if (vpass)                        nxt = pick_any ? ST_ESU_ON : ST_SWE_OFF;
                    else if (tries >= TW'(TRY_MAX))   nxt = ST_SWE_OFF;
                    else                              nxt = ST_ESU_ON;
                end
            end
            ST_SWE_OFF: if (expired) nxt = ST_FIN;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            pend   <= '0;
            cur    <= '0;
            wcnt   <= '0;
            tries  <= '0;
            vpass  <= 1'b0;
            fail_q <= 1'b0;
            fidx_q <= '0;
        end else begin
            state <= nxt;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        fidx_q <= '0;
                        if (pick_any) begin
                            pend   <= req_blocks;
                            cur    <= pick_idx;
                            tries  <= TW'(1);
                            fail_q <= 1'b0;
                        end else begin
                            fail_q <= 1'b1;
                        end
                    end
                end
                ST_EV_ON: begin
                    wcnt  <= '0;
                    vpass <= 1'b0;
                end
                ST_VRD: begin
                    if (word_ok) begin
                        if (word_last) vpass <= 1'b1;
                        else           wcnt  <= wcnt + 1'b1;
                    end
                end
                ST_EV_OFF: begin
                    if (expired) begin
                        if (vpass) begin
                            pend <= rest;
                            if (pick_any) begin
                                cur   <= pick_idx;
                                tries <= TW'(1);
                            end
                        end else if (tries >= TW'(TRY_MAX)) begin
                            fail_q <= 1'b1;
                            fidx_q <= cur;
                        end else begin
                            tries <= tries + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign stb              = strobes_of(state);
    assign busy             = (state != ST_IDLE);
    assign done             = (state == ST_FIN);
    assign fail             = fail_q;
    assign fail_block_index = fidx_q;
    assign flash_swe        = stb.swe;
    assign flash_blk_sel    = stb.sel ? (NB'(1) << cur) : '0;
    assign flash_esu        = stb.esu;
    assign flash_epulse     = stb.pulse;
    assign flash_ev         = stb.ev;
    assign wdt_en           = stb.wdt;
    assign mem_wr           = stb.wr;
    assign mem_rd           = stb.rd;
    assign mem_wdata        = DUMMY_BYTE;
    assign mem_addr         = AW'(cur) * AW'(BLK_WORDS) + AW'(wcnt);

    // R2
    esu_needs_swe_chk: assert property (@(posedge clk) disable iff (rst)
        flash_esu |-> flash_swe);

    // R4
    pulse_guarded_chk: assert property (@(posedge clk) disable iff (rst)
        flash_epulse |-> (wdt_en && flash_esu && $onehot(flash_blk_sel)));

    // R3
    sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(flash_blk_sel));

    // R11
    wr_in_verify_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> (flash_ev && !flash_esu && mem_wdata == 8'hFF));

    // R5
    rd_after_wait_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> (flash_ev && $past(expired)));

    // R7
    try_bound_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (tries <= TW'(TRY_MAX)));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));
endmodule

// File: tb/erase_seq_tb.sv
module erase_seq_tb;
    localparam int NB = 4, BW = 8, TRY = 3;
    localparam int DX = 3, DY = 2, DZ = 12, DA = 2, DB = 2, DG = 3, DE = 1, DH = 2, DT = 4;
    localparam int AW = $clog2(NB * BW);

    logic clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic [NB-1:0] req_blocks = '0;
    logic busy, done, fail, flash_swe, flash_esu, flash_epulse, flash_ev, wdt_en, mem_wr, mem_rd;
    logic [1:0] fail_block_index;
    logic [NB-1:0] flash_blk_sel;
    logic [7:0] mem_wdata;
    logic [AW-1:0] mem_addr;
    logic [15:0] mem_rdata;

    always #10 clk = ~clk;

    erase_seq #(.NB(NB), .BLK_WORDS(BW), .DATA_W(16), .TRY_MAX(TRY), .CNT_W(20),
        .D_SWE_ON(DX), .D_ESU_ON(DY), .D_EP_ON(DZ), .D_EP_OFF(DA), .D_ESU_OFF(DB),
        .D_EV_ON(DG), .D_VWAIT(DE), .D_EV_OFF(DH), .D_SWE_OFF(DT)) u_dut (
        .clk(clk), .rst(rst), .start(start), .req_blocks(req_blocks),
        .busy(busy), .done(done), .fail(fail), .fail_block_index(fail_block_index),
        .flash_swe(flash_swe), .flash_blk_sel(flash_blk_sel), .flash_esu(flash_esu),
        .flash_epulse(flash_epulse), .flash_ev(flash_ev), .wdt_en(wdt_en),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rd(mem_rd),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata));

    // Array model: a chosen word reads a bad value until the block has had enough pulses
    int pulses [NB];
    int pbase  [NB];
    int kneed  [NB];
    int badw   [NB];
    logic [15:0] badv [NB];
    logic ep_q = 1'b0;

    initial for (int i = 0; i < NB; i++) pulses[i] = 0;

    always @(posedge clk) begin
        ep_q <= flash_epulse;
        if (flash_epulse && !ep_q)
            for (int i = 0; i < NB; i++) if (flash_blk_sel[i]) pulses[i] = pulses[i] + 1;
    end

    always_comb begin
        mem_rdata = 16'hFFFF;
        if ((pulses[mem_addr / BW] - pbase[mem_addr / BW]) < kneed[mem_addr / BW] &&
            (mem_addr % BW) == badw[mem_addr / BW])
            mem_rdata = badv[mem_addr / BW];
    end

    // Expected port values
    logic e_busy = 0, e_done = 0, e_fail = 0, e_swe = 0, e_esu = 0, e_ep = 0, e_ev = 0;
    logic e_wdt = 0, e_wr = 0, e_rd = 0, cmp_en = 0;
    logic [1:0] e_fidx = 0;
    logic [NB-1:0] e_sel = 0;
    int e_addr = 0;
    int n_chk = 0, n_fail = 0;

    task automatic chk(input logic ok, input string tag, input string nm,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (ok !== 1'b1) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, nm, act, exp, $time);
        end
    endtask

    always @(negedge clk) if (cmp_en) begin
        chk(busy === e_busy, "R10", "busy", 32'(busy), 32'(e_busy));
        chk(done === e_done, "R9", "done", 32'(done), 32'(e_done));
        chk(fail === e_fail, "R8", "fail", 32'(fail), 32'(e_fail));
        chk(fail_block_index === e_fidx, "R8", "fail_block_index", 32'(fail_block_index), 32'(e_fidx));
        chk(flash_swe === e_swe, "R2", "swe", 32'(flash_swe), 32'(e_swe));
        chk(flash_blk_sel === e_sel, "R3", "blk_sel", 32'(flash_blk_sel), 32'(e_sel));
        chk(flash_esu === e_esu, "R4", "esu", 32'(flash_esu), 32'(e_esu));
        chk(flash_epulse === e_ep, "R4", "epulse", 32'(flash_epulse), 32'(e_ep));
        chk(wdt_en === e_wdt, "R4", "wdt_en", 32'(wdt_en), 32'(e_wdt));
        chk(flash_ev === e_ev, "R5", "ev", 32'(flash_ev), 32'(e_ev));
        chk(mem_rd === e_rd, "R5", "mem_rd", 32'(mem_rd), 32'(e_rd));
        chk(mem_wr === e_wr, "R11", "mem_wr", 32'(mem_wr), 32'(e_wr));
        if (e_wr || e_rd)
            chk(mem_addr === AW'(e_addr), "R5", "mem_addr", 32'(mem_addr), 32'(e_addr));
        if (e_wr)
            chk(mem_wdata === 8'hFF, "R11", "mem_wdata", 32'(mem_wdata), 32'hFF);
    end

    task automatic hold(input int cyc, input bit swe, input int blk, input bit esu, input bit ep,
                        input bit wdt, input bit ev, input bit wr, input bit rd, input int addr);
        e_swe = swe; e_sel = (blk < 0) ? '0 : NB'(1) << blk;
        e_esu = esu; e_ep = ep; e_wdt = wdt; e_ev = ev; e_wr = wr; e_rd = rd; e_addr = addr;
        repeat (cyc) @(posedge clk);
        #1;
    endtask

    task automatic run_op(input logic [NB-1:0] mask, input bit glitch);
        bit failed;
        int fblk, n, last;
        failed = 0; fblk = 0;
        for (int i = 0; i < NB; i++) pbase[i] = pulses[i];
        @(negedge clk);
        start = 1'b1; req_blocks = mask;
        if (glitch) fork
            begin
                repeat (25) @(negedge clk);
                start = 1'b1; req_blocks = '1;
                @(negedge clk);
                start = 1'b0;
            end
        join_none
        @(posedge clk);
        #1;
        start = 1'b0;
        if (mask == '0) begin
            e_busy = 1; e_done = 1; e_fail = 1; e_fidx = 0;
            hold(1, 0, -1, 0, 0, 0, 0, 0, 0, 0);
            e_busy = 0; e_done = 0;
            return;
        end
        e_busy = 1; e_fail = 0; e_fidx = 0;
        hold(DX + 1, 1, -1, 0, 0, 0, 0, 0, 0, 0);
        for (int b = 0; b < NB; b++) begin
            if (mask[b] && !failed) begin
                n = 1;
                while (1) begin
                    hold(DY + 1, 1, b, 1, 0, 1, 0, 0, 0, 0);
                    hold(DZ + 1, 1, b, 1, 1, 1, 0, 0, 0, 0);
                    hold(DA + 1, 1, b, 1, 0, 1, 0, 0, 0, 0);
                    hold(DB + 1, 1, b, 0, 0, 1, 0, 0, 0, 0);
                    hold(DG + 1, 1, b, 0, 0, 0, 1, 0, 0, 0);
                    last = (n >= kneed[b]) ? BW - 1 : badw[b];
                    for (int w = 0; w <= last; w++) begin
                        hold(1, 1, b, 0, 0, 0, 1, 1, 0, b * BW + w);
                        hold(DE + 1, 1, b, 0, 0, 0, 1, 0, 0, 0);
                        hold(1, 1, b, 0, 0, 0, 1, 0, 1, b * BW + w);
                    end
                    hold(DH + 1, 1, b, 0, 0, 0, 0, 0, 0, 0);
                    if (n >= kneed[b]) break;
                    if (n >= TRY) begin failed = 1; fblk = b; break; end
                    n++;
                end
            end
        end
        e_fail = failed; e_fidx = failed ? 2'(fblk) : 2'd0;
        hold(DT + 1, 0, -1, 0, 0, 0, 0, 0, 0, 0);
        e_done = 1;
        hold(1, 0, -1, 0, 0, 0, 0, 0, 0, 0);
        e_done = 0; e_busy = 0;
    endtask

    task automatic finish_tb;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_tb();
    end

    initial begin
        for (int i = 0; i < NB; i++) begin
            pbase[i] = 0; kneed[i] = 0; badw[i] = 0; badv[i] = 16'hFFFF;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(!busy && !done && !fail && !flash_swe && flash_blk_sel == '0 && !flash_esu &&
            !flash_epulse && !flash_ev && !wdt_en && !mem_wr && !mem_rd && fail_block_index == 0,
            "R1", "reset outputs", {busy, done, fail, flash_swe, flash_esu, flash_epulse}, 0);
        rst = 1'b0;
        #1 cmp_en = 1'b1;
        repeat (2) @(posedge clk);
        #1;

        // R2 R4 R5 R9: block 1, clean on first attempt
        kneed[1] = 1; badw[1] = 2; badv[1] = 16'h7FFF;
        run_op(4'b0010, 0);
        chk(pulses[1] - pbase[1] == 1, "R9", "block1 pulses", 32'(pulses[1] - pbase[1]), 1);

        // R6: single cleared bit at the last word forces one retry
        kneed[2] = 2; badw[2] = BW - 1; badv[2] = 16'hFFFE;
        run_op(4'b0100, 0);
        chk(pulses[2] - pbase[2] == 2, "R6", "block2 pulses", 32'(pulses[2] - pbase[2]), 2);

        // R7 R10: three blocks, block1 passes on its last attempt, block3 needs a retry,
        // and a second start arrives mid-run
        kneed[0] = 1; kneed[1] = TRY; badw[1] = 0; badv[1] = 16'h0000;
        kneed[3] = 2; badw[3] = 4; badv[3] = 16'hFF7F;
        run_op(4'b1011, 1);
        chk(pulses[1] - pbase[1] == TRY, "R7", "block1 pulses", 32'(pulses[1] - pbase[1]), TRY);
        chk(pulses[3] - pbase[3] == 2, "R7", "block3 pulses", 32'(pulses[3] - pbase[3]), 2);
        chk(pulses[2] - pbase[2] == 0, "R10", "block2 untouched", 32'(pulses[2] - pbase[2]), 0);

        // R8: block2 never clears, block3 must not be started
        kneed[2] = 10; badw[2] = 0; badv[2] = 16'h8000; kneed[3] = 1;
        run_op(4'b1100, 0);
        chk(pulses[2] - pbase[2] == TRY, "R8", "block2 pulses", 32'(pulses[2] - pbase[2]), TRY);
        chk(pulses[3] - pbase[3] == 0, "R8", "block3 skipped", 32'(pulses[3] - pbase[3]), 0);
        repeat (3) @(posedge clk);
        #1;

        // R3: empty mask rejected with no pulse anywhere
        run_op(4'b0000, 0);
        chk(pulses[0] - pbase[0] == 0, "R3", "no pulse on reject", 32'(pulses[0] - pbase[0]), 0);

        // R9: a following good run clears fail
        kneed[3] = 1; badw[3] = 0;
        run_op(4'b1000, 0);
        repeat (3) @(posedge clk);
        #1;
        finish_tb();
    end
endmodule